// File: doc/BRIEF.md
# Divide and Multiply Occupancy Tracker

This block sits beside the integer execute pipe and follows how long the integer divider and the multiplier stay occupied. It also follows when they will write the hi/lo result pair. It carries no arithmetic. It sees one-cycle issue requests for 32-bit and 64-bit divides and multiplies, and for hi/lo reads and writes. For each request it answers in the same cycle whether that request must be held back.

The divider is not pipelined, but its busy window starts only four cycles after issue. It ends on the latency cycle. A following divide can therefore issue while the previous one is still in its last four cycles. At most two divides are in flight at once, and the block follows each of them separately. It pulses a done flag on each latency cycle. It marks the hi/lo write strobes four cycles later. Until that write, any hi/lo access and any multiply is held. The multiplier writes its results after a fixed delay. A 64-bit multiply writes its high half one cycle late and keeps any other multiply out for the next cycle.

A stalled request is dropped, not queued. The issuing logic must present it again in a later cycle.

Top module: `div_occupancy`

## Requirements
- R1: While `rst` is high, every output is 0, even with all requests asserted. Reset clears all in-flight state.
- R2: A 32-bit divide accepted in cycle t raises `div_done_o` for exactly the one cycle t+36. This is lead 4 plus hold 32.
- R3: A 64-bit divide accepted in cycle t raises `div_done_o` for exactly the one cycle t+68. This is lead 4 plus hold 64.
- R4: After a divide accepted in cycle t with hold H, a divide request is stalled in cycles t+1 to t+H-1. It is accepted in cycle t+H, which overlaps the previous divide's last four cycles.
- R5: After a divide accepted in cycle t with hold H, `hilo_stall_o` is high whenever a hi/lo read or write is requested in cycles t+1 to t+H+8. It is low again from t+H+9.
- R6: A multiply request is stalled in the same window as R5.
- R7: A divide with latency cycle t+H+4 raises `lo_wr_o` and `hi_wr_o` together in cycle t+H+8.
- R8: A 32-bit multiply accepted in cycle t raises both `lo_wr_o` and `hi_wr_o` in cycle t+7.
- R9: A 64-bit multiply accepted in cycle t raises `lo_wr_o` in cycle t+7 and `hi_wr_o` in cycle t+8.
- R10: After a 64-bit multiply is accepted in cycle t, any multiply request in cycle t+1 is stalled. In cycle t+2 a request is free of this block.
- R11: A stalled divide or multiply request leaves no trace. It causes no done pulse, no write strobe and no change of later stalls.
- R12: When both widths are requested in one cycle, the 64-bit operation is the one accepted.
- R13: A stall output is high only in a cycle where its own request input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| div32_req_i | input | 1 | Request to issue a 32-bit divide this cycle |
| div64_req_i | input | 1 | Request to issue a 64-bit divide this cycle |
| mul32_req_i | input | 1 | Request to issue a 32-bit multiply this cycle |
| mul64_req_i | input | 1 | Request to issue a 64-bit multiply this cycle |
| hilo_rd_i | input | 1 | Request to read hi/lo this cycle |
| hilo_wr_i | input | 1 | Request to write hi/lo this cycle |
| div_stall_o | output | 1 | The divide request of this cycle is refused |
| mul_stall_o | output | 1 | The multiply request of this cycle is refused |
| hilo_stall_o | output | 1 | The hi/lo access of this cycle is refused |
| div_done_o | output | 1 | Latency cycle of a divide |
| lo_wr_o | output | 1 | lo is written by a divide or multiply this cycle |
| hi_wr_o | output | 1 | hi is written by a divide or multiply this cycle |

## Verification
For both divide widths, a second divide is requested at every gap from one cycle up to one past the hold. This separates the refused gaps, whose requests must leave no trace, from the first accepted gap, where the two divides overlap. Each gap shows whether the done pulses and write strobes of both divides stay distinct. Every combination of none, 32-bit, 64-bit and both-width multiply requests is swept over four consecutive cycles. This separates the one-cycle lock after a 64-bit multiply and the late high-half write from the 32-bit timing. Multiplies and hi/lo accesses are also held against divides of both widths, which finds the exact cycle where the hi/lo lock lifts.

// File: rtl/div_occupancy.sv
module div_occupancy #(
  parameter int HOLD32   = 32,
  parameter int HOLD64   = 64,
  parameter int LEAD     = 4,
  parameter int HILO_GAP = 4,
  parameter int MUL_WB   = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic div32_req_i,
  input  logic div64_req_i,
  input  logic mul32_req_i,
  input  logic mul64_req_i,
  input  logic hilo_rd_i,
  input  logic hilo_wr_i,
  output logic div_stall_o,
  output logic mul_stall_o,
  output logic hilo_stall_o,
  output logic div_done_o,
  output logic lo_wr_o,
  output logic hi_wr_o
);
  localparam int HMAX = (HOLD64 > HOLD32) ? HOLD64 : HOLD32;
  localparam int CW   = $clog2(LEAD + HMAX + HILO_GAP + 1);
  localparam logic [CW-1:0] LOAD32  = CW'(LEAD + HOLD32 + HILO_GAP);
  localparam logic [CW-1:0] LOAD64  = CW'(LEAD + HOLD64 + HILO_GAP);
  localparam logic [CW-1:0] OPEN_AT = CW'(LEAD + HILO_GAP + 1);
  localparam logic [CW-1:0] DONE_AT = CW'(HILO_GAP + 1);
  localparam logic [CW-1:0] WR_AT   = CW'(1);

  logic ptr, mul64_blk;
  logic [1:0] slot_busy, slot_live, slot_done, slot_wr;
  logic [MUL_WB-1:0] sh32;
  logic [MUL_WB:0]   sh64;

  wire div_req   = div32_req_i | div64_req_i;
  wire div_go    = div_req & ~(|slot_busy);
  wire [CW-1:0] div_load = div64_req_i ? LOAD64 : LOAD32;
  wire in_flight = |slot_live;
  wire mul_req   = mul32_req_i | mul64_req_i;
  wire mul_hold  = in_flight | mul64_blk;
  wire mul_go    = mul_req & ~mul_hold;
  wire div_wr    = |slot_wr;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                          cnt <= '0;
      else if (div_go && ptr == 1'(s))  cnt <= div_load;
      else if (cnt != '0)               cnt <= cnt - 1'b1;
    end
    assign slot_busy[s] = cnt > OPEN_AT;
    assign slot_live[s] = cnt != '0;
    assign slot_done[s] = cnt == DONE_AT;
    assign slot_wr[s]   = cnt == WR_AT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= 1'b0;
      mul64_blk <= 1'b0;
      sh32      <= '0;
      sh64      <= '0;
    end else begin
      ptr       <= ptr ^ div_go;
      mul64_blk <= mul_go & mul64_req_i;
      sh32      <= {sh32[MUL_WB-2:0], mul_go & ~mul64_req_i};
      sh64      <= {sh64[MUL_WB-1:0], mul_go &  mul64_req_i};
    end
  end

  assign div_stall_o  = div_req & ~div_go;
  assign mul_stall_o  = mul_req & mul_hold;
  assign hilo_stall_o = (hilo_rd_i | hilo_wr_i) & in_flight;
  assign div_done_o   = |slot_done;
  assign lo_wr_o      = sh32[MUL_WB-1] | sh64[MUL_WB-1] | div_wr;
  assign hi_wr_o      = sh32[MUL_WB-1] | sh64[MUL_WB]   | div_wr;
endmodule

// File: rtl/div_occupancy_chk.sv
module div_occupancy_chk #(
  parameter int HILO_GAP = 4,
  parameter int MUL_WB   = 7
) (
  input logic clk,
  input logic rst,
  input logic div32_req_i,
  input logic div64_req_i,
  input logic mul32_req_i,
  input logic mul64_req_i,
  input logic hilo_rd_i,
  input logic hilo_wr_i,
  input logic div_stall_o,
  input logic mul_stall_o,
  input logic hilo_stall_o,
  input logic div_done_o,
  input logic lo_wr_o,
  input logic hi_wr_o
);
  wire mul_acc   = (mul32_req_i | mul64_req_i) & ~mul_stall_o;
  wire mul64_acc = mul64_req_i & ~mul_stall_o;

  AST_MUL64_LOCKS_NEXT: assert property (@(posedge clk) disable iff (rst)
    mul64_acc |=> (!(mul32_req_i || mul64_req_i) || mul_stall_o)); // R10
  AST_MUL_LO_DELAY: assert property (@(posedge clk) disable iff (rst)
    mul_acc |-> ##MUL_WB lo_wr_o); // R8
  AST_MUL64_HI_LATE: assert property (@(posedge clk) disable iff (rst)
    mul64_acc |-> ##(MUL_WB + 1) hi_wr_o); // R9
  AST_DIV_WRITES_PAIR: assert property (@(posedge clk) disable iff (rst)
    div_done_o |-> ##HILO_GAP (lo_wr_o && hi_wr_o)); // R7
  AST_HILO_HELD_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (div_done_o && (hilo_rd_i || hilo_wr_i)) |-> hilo_stall_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_done_o |=> !div_done_o); // R2
  AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    div_stall_o |-> (div32_req_i || div64_req_i)); // R13
endmodule

bind div_occupancy div_occupancy_chk #(.HILO_GAP(HILO_GAP), .MUL_WB(MUL_WB)) u_chk (.*);

// File: tb/tb_div_occupancy.sv
module tb_div_occupancy;
  localparam int H32 = 32, H64 = 64, LEAD = 4, GAP = 4, MW = 7, MAXC = 32768;

  logic clk = 0, rst = 1;
  logic d32 = 0, d64 = 0, m32 = 0, m64 = 0, rd = 0, wr = 0;
  logic div_stall, mul_stall, hilo_stall, done, lo_wr, hi_wr;

  always #5 clk = ~clk;

  div_occupancy dut (
    .clk(clk), .rst(rst),
    .div32_req_i(d32), .div64_req_i(d64), .mul32_req_i(m32), .mul64_req_i(m64),
    .hilo_rd_i(rd), .hilo_wr_i(wr),
    .div_stall_o(div_stall), .mul_stall_o(mul_stall), .hilo_stall_o(hilo_stall),
    .div_done_o(done), .lo_wr_o(lo_wr), .hi_wr_o(hi_wr));

  int checks = 0, fails = 0, c = 0;
  bit acc32 [MAXC];
  bit acc64 [MAXC];
  int dt [2] = '{-1000, -1000};
  int dh [2] = '{H32, H32};
  int last = 0;
  string phase = "R1";

  task automatic chk(input string tag, input string name, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s: got %b expected %b at cycle %0d", tag, phase, name, got, exp, c);
    end
  endtask

  task automatic step(input bit a32, input bit a64, input bit b32, input bit b64,
                      input bit r, input bit w);
    bit busy, infl, dn, dw, blk, mreq, dreq, ms, ds, lo, hi;
    int nw;
    @(negedge clk);
    d32 = a32; d64 = a64; m32 = b32; m64 = b64; rd = r; wr = w;
    #1;
    busy = (c - dt[last]) < dh[last];
    infl = 0; dn = 0; dw = 0;
    for (int i = 0; i < 2; i++) begin
      int a;
      a = c - dt[i];
      if (a >= 1 && a <= dh[i] + LEAD + GAP) infl = 1;
      if (a == dh[i] + LEAD) dn = 1;
      if (a == dh[i] + LEAD + GAP) dw = 1;
    end
    blk  = (c >= 1) && acc64[c-1];
    mreq = b32 | b64;
    dreq = a32 | a64;
    ms   = mreq && (infl || blk);
    ds   = dreq && busy;
    lo   = dw || (c >= MW && (acc32[c-MW] || acc64[c-MW]));
    hi   = dw || (c >= MW && acc32[c-MW]) || (c >= MW + 1 && acc64[c-MW-1]);
    chk("R4",       "div_stall",  div_stall,  ds);
    chk("R6/R10",   "mul_stall",  mul_stall,  ms);
    chk("R5",       "hilo_stall", hilo_stall, (r | w) && infl);
    chk("R2/R3",    "div_done",   done,       dn);
    chk("R7/R8/R9", "lo_wr",      lo_wr,      lo);
    chk("R7/R8/R9", "hi_wr",      hi_wr,      hi);
    if (mreq && !ms) begin
      if (b64) acc64[c] = 1; else acc32[c] = 1;
    end
    if (dreq && !ds) begin
      nw = 1 - last;
      dt[nw] = c;
      dh[nw] = a64 ? H64 : H32;
      last = nw;
    end
    @(posedge clk);
    c++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: all requests high during reset
    d32 = 1; d64 = 1; m32 = 1; m64 = 1; rd = 1; wr = 1;
    repeat (2) @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R1", "div_stall",  div_stall,  1'b0);
      chk("R1", "mul_stall",  mul_stall,  1'b0);
      chk("R1", "hilo_stall", hilo_stall, 1'b0);
      chk("R1", "div_done",   done,       1'b0);
      chk("R1", "lo_wr",      lo_wr,      1'b0);
      chk("R1", "hi_wr",      hi_wr,      1'b0);
    end
    @(negedge clk);
    rst = 0; d32 = 0; d64 = 0; m32 = 0; m64 = 0; rd = 0; wr = 0;
    @(posedge clk);

    // R2 R3 R4 R11: second divide at every gap
    for (int w = 0; w < 2; w++) begin
      int h;
      h = w ? H64 : H32;
      for (int g = 1; g <= h + 1; g++) begin
        phase = (g < h) ? "R11" : (w ? "R3" : "R2");
        step(!w, w, 0, 0, 0, 0);
        for (int k = 1; k <= 2 * (h + LEAD + GAP) + 3; k++)
          step(k == g && !w, k == g && w, 0, 0, k % 2 == 0, k % 2 == 1);
      end
    end

    // R12: both divide widths at once
    phase = "R12";
    step(1, 1, 0, 0, 0, 0);
    for (int k = 1; k <= H64 + LEAD + GAP + 3; k++) step(0, 0, 0, 0, 1, 0);

    // R8 R9 R10 R12: multiply request patterns over four cycles
    phase = "R8";
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 4; k++) begin
        int code;
        code = (p >> (2 * k)) & 3;
        step(0, 0, code[0], code[1], k == 1, k == 2);
      end
      for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 0, 0);
    end

    // R6: multiplies held behind divides of both widths
    phase = "R6";
    for (int w = 0; w < 2; w++) begin
      int h;
      h = w ? H64 : H32;
      step(!w, w, 0, 0, 0, 0);
      for (int k = 1; k <= h + LEAD + GAP + 2; k++) step(0, 0, 1, 0, 0, 1);
      for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 0, 0);
    end

    // R13: no requests, no stalls
    phase = "R13";
    step(1, 0, 0, 0, 0, 0);
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < H32 + 20; k++) step(0, 0, 0, 0, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule